// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block keeps a small table of unsigned words in an internal single-port RAM and rearranges them in place into non-decreasing order. Software or a neighbouring block first fills the table while the mode input is low, using a plain write port with an address and a data word. Raising the mode input and then the start input launches the sort. Sorting is done by a nested compare-and-exchange pass. An outer index picks a slot and holds its value in a working register. An inner index sweeps every later slot. Whenever the held value is larger than the scanned one, the two slots are exchanged.

When the last comparison is finished, a done flag rises and stays high for as long as start is held. Dropping start returns the controller to idle. With mode low again, the sorted table can be read back through the same address port. Read data comes out of a registered output one clock after the request. The table has 2^ADDR_W entries of DATA_W bits each, and reset is synchronous and active high.

Top module: `exchange_sorter`

## Requirements
- R1: A high `rst` at a rising edge clears `done` and puts the controller into idle. This holds even in the middle of a sort, and after reset the external write and read ports work at once.
- R2: With `mode`=0 and the controller idle, a high `wr_en` at a rising edge stores `din` into the entry selected by `addr`.
- R3: With `mode`=0 and the controller idle, a high `rd_en` at a rising edge puts the entry at `addr` on `dout` after that edge. While no read is made, `dout` keeps its last value.
- R4: A rising edge that sees the controller idle with `mode`=1 and `start`=1 begins a sort. `start` has no effect while `mode`=0: `done` stays low and the table is unchanged.
- R5: When `done` rises, the table holds exactly the words it held before the sort, arranged in non-decreasing unsigned order from address 0 upward.
- R6: `done` rises only once the last pair has been compared, and it stays high while `start` is 1. At the first rising edge with `start`=0, `done` falls and the controller returns to idle.
- R7: A write request is ignored while `mode`=1, whether the controller is idle or sorting.
- R8: A pair is exchanged only when the held value is strictly greater than the scanned value. The exchange takes two consecutive write cycles: first the outer slot, then the inner slot.
- R9: The outer index covers 0 to 2^ADDR_W-2 and the inner index runs from one above the outer index to 2^ADDR_W-1. As a result, address 0 ends up with the minimum and the last address with the maximum.
- R10: Tables that are all equal, already sorted, reverse sorted, or that contain 0 and 2^DATA_W-1 are all sorted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = external load/read, 1 = sort |
| start | input | 1 | Launches a sort in sort mode; its return to 0 releases done |
| wr_en | input | 1 | External write request |
| rd_en | input | 1 | External read request |
| addr | input | ADDR_W | External table address |
| din | input | DATA_W | External write data |
| dout | output | DATA_W | Registered read data |
| done | output | 1 | Sort complete, held until start falls |

## Verification
The assertions check the controller on every cycle. They cover the reset state, the launch condition, the hold and release of `done` around `start`, the rule that `done` rises only after a final compare or exchange, the two-cycle exchange order, and the bounds of both indices. The bench scenarios are needed for the rest. Only they can show that the table ends up as a sorted permutation of what was loaded, that blocked writes really leave the contents unchanged, that `dout` holds between reads, and that duplicates, extreme values and presorted or reversed tables come out right.

// File: rtl/exsort_pkg.sv
package exsort_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_LDA,
    ST_RDB,
    ST_CMP,
    ST_WRI,
    ST_WRJ,
    ST_DONE
  } st_e;

  typedef enum logic [1:0] {
    AS_EXT,
    AS_I,
    AS_J
  } asel_e;

  typedef enum logic [1:0] {
    WS_EXT,
    WS_B,
    WS_A
  } wsel_e;

  typedef struct packed {
    logic  mem_we;
    logic  mem_re;
    asel_e asel;
    wsel_e wsel;
    logic  i_clr;
    logic  i_inc;
    logic  j_load;
    logic  j_inc;
    logic  a_from_q;
    logic  a_from_b;
    logic  b_load;
  } ctl_t;

endpackage

// File: rtl/exsort_ram.sv
module exsort_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, synchronous read with enable: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/exsort_datapath.sv
module exsort_datapath
  import exsort_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_din,
  output logic [DATA_W-1:0] rdata,
  output logic              gt,
  output logic              i_last,
  output logic              j_last,
  output logic [ADDR_W-1:0] i_idx,
  output logic [ADDR_W-1:0] j_idx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] I_END = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] J_END = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);

  logic [ADDR_W-1:0] i_q, j_q, mem_addr;
  logic [DATA_W-1:0] a_q, b_q, mem_wdata;

  // index counters and working registers
  always_ff @(posedge clk) begin
    if (rst) begin
      i_q <= '0;
      j_q <= '0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ctl.i_clr)      i_q <= '0;
      else if (ctl.i_inc) i_q <= i_q + ONE;
      if (ctl.j_load)     j_q <= i_q + ONE;
      else if (ctl.j_inc) j_q <= j_q + ONE;
      if (ctl.a_from_q)      a_q <= rdata;
      else if (ctl.a_from_b) a_q <= b_q;
      if (ctl.b_load) b_q <= rdata;
    end
  end

  always_comb begin
    case (ctl.asel)
      AS_I:    mem_addr = i_q;
      AS_J:    mem_addr = j_q;
      default: mem_addr = ext_addr;
    endcase
    case (ctl.wsel)
      WS_B:    mem_wdata = b_q;
      WS_A:    mem_wdata = a_q;
      default: mem_wdata = ext_din;
    endcase
  end

  exsort_ram #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk  (clk),
    .we   (ctl.mem_we),
    .re   (ctl.mem_re),
    .addr (mem_addr),
    .wdata(mem_wdata),
    .rdata(rdata)
  );

  // held value against the word just read from the inner slot
  assign gt     = a_q > rdata;
  assign i_last = (i_q == I_END);
  assign j_last = (j_q == J_END);
  assign i_idx  = i_q;
  assign j_idx  = j_q;
endmodule

// File: rtl/exsort_ctrl.sv
module exsort_ctrl
  import exsort_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic start,
  input  logic wr_en,
  input  logic rd_en,
  input  logic gt,
  input  logic i_last,
  input  logic j_last,
  output ctl_t ctl,
  output st_e  state,
  output logic done
);
  st_e state_q, state_d;
  logic done_q;

  always_comb begin
    ctl      = '0;
    ctl.asel = AS_EXT;
    ctl.wsel = WS_EXT;
    state_d  = state_q;

    case (state_q)
      ST_IDLE: begin
        if (!mode) begin
          ctl.mem_we = wr_en;
          ctl.mem_re = rd_en;
        end else if (start) begin
          ctl.i_clr = 1'b1;
          state_d   = ST_RDA;
        end
      end
      ST_RDA: begin
        ctl.asel   = AS_I;
        ctl.mem_re = 1'b1;
        ctl.j_load = 1'b1;
        state_d    = ST_LDA;
      end
      ST_LDA: begin
        ctl.asel     = AS_J;
        ctl.mem_re   = 1'b1;
        ctl.a_from_q = 1'b1;
        state_d      = ST_CMP;
      end
      ST_RDB: begin
        ctl.asel   = AS_J;
        ctl.mem_re = 1'b1;
        state_d    = ST_CMP;
      end
      ST_CMP: begin
        ctl.b_load = 1'b1;
        if (gt) begin
          state_d = ST_WRI;
        end else if (!j_last) begin
          ctl.j_inc = 1'b1;
          state_d   = ST_RDB;
        end else if (!i_last) begin
          ctl.i_inc = 1'b1;
          state_d   = ST_RDA;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_WRI: begin
        ctl.asel   = AS_I;
        ctl.wsel   = WS_B;
        ctl.mem_we = 1'b1;
        state_d    = ST_WRJ;
      end
      ST_WRJ: begin
        ctl.asel     = AS_J;
        ctl.wsel     = WS_A;
        ctl.mem_we   = 1'b1;
        ctl.a_from_b = 1'b1;
        if (!j_last) begin
          ctl.j_inc = 1'b1;
          state_d   = ST_RDB;
        end else if (!i_last) begin
          ctl.i_inc = 1'b1;
          state_d   = ST_RDA;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!start) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_d == ST_DONE);
    end
  end

  assign state = state_q;
  assign done  = done_q;
endmodule

// File: rtl/exchange_sorter.sv
module exchange_sorter
  import exsort_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              start,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              done
);
  ctl_t              ctl;
  st_e               state;
  logic              gt, i_last, j_last, ram_we;
  logic [ADDR_W-1:0] i_idx, j_idx;

  exsort_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .start (start),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .gt    (gt),
    .i_last(i_last),
    .j_last(j_last),
    .ctl   (ctl),
    .state (state),
    .done  (done)
  );

  exsort_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .ext_addr(addr),
    .ext_din (din),
    .rdata   (dout),
    .gt      (gt),
    .i_last  (i_last),
    .j_last  (j_last),
    .i_idx   (i_idx),
    .j_idx   (j_idx)
  );

  assign ram_we = ctl.mem_we;
endmodule

// File: rtl/exchange_sorter_chk.sv
module exchange_sorter_chk
  import exsort_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mode,
  input logic              start,
  input logic              done,
  input st_e               state,
  input logic              ram_we,
  input logic [ADDR_W-1:0] i_idx,
  input logic [ADDR_W-1:0] j_idx
);
  localparam logic [ADDR_W-1:0] I_MAX = ADDR_W'((1 << ADDR_W) - 2);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && !done));

  p_init_stays_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !mode) |=> state == ST_IDLE);

  p_launch_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && mode && start) |=> state == ST_RDA);

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done);

  p_done_release_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (!done && state == ST_IDLE));

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(state) == ST_CMP || $past(state) == ST_WRJ));

  p_blocked_write_r7: assert property (@(posedge clk) disable iff (rst)
    (ram_we && mode) |-> (state == ST_WRI || state == ST_WRJ));

  p_swap_order_r8: assert property (@(posedge clk) disable iff (rst)
    state == ST_WRI |=> state == ST_WRJ);

  p_index_range_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LDA || state == ST_RDB || state == ST_CMP ||
     state == ST_WRI || state == ST_WRJ) |-> (j_idx > i_idx && i_idx <= I_MAX));
endmodule

bind exchange_sorter exchange_sorter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .mode  (mode),
  .start (start),
  .done  (done),
  .state (state),
  .ram_we(ram_we),
  .i_idx (i_idx),
  .j_idx (j_idx)
);

// File: tb/exchange_sorter_bench.sv
`timescale 1ns/1ps
module exchange_sorter_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int K  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode = 1'b0, start = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] img [K];

  always #2.5 clk = ~clk;

  exchange_sorter #(.DATA_W(DW), .ADDR_W(AW)) u_exchange_sorter (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .din(din), .dout(dout), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic m);
    @(negedge clk);
    mode = m; wr_en = 1'b1; addr = a; din = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    mode = 1'b0; rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = dout; rd_en = 1'b0;
  endtask

  task automatic load_img();
    for (int n = 0; n < K; n++) wr(AW'(n), img[n], 1'b0);
  endtask

  // compare the whole table against img, one check per entry
  task automatic verify(input string req, input string what);
    logic [DW-1:0] v;
    for (int n = 0; n < K; n++) begin
      rd(AW'(n), v);
      check(v === img[n], req, what, v, img[n]);
    end
  endtask

  function automatic void sort_img();
    for (int p = 1; p < K; p++) begin
      for (int q = p; q > 0; q--) begin
        if (img[q-1] > img[q]) begin
          logic [DW-1:0] t;
          t = img[q-1]; img[q-1] = img[q]; img[q] = t;
        end
      end
    end
  endfunction

  // run one sort; when poke is set, try writes during the run (R7)
  task automatic run_sort(input bit poke);
    int n;
    @(negedge clk);
    mode = 1'b1; start = 1'b1;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      if (poke) begin
        wr_en = 1'b1; addr = AW'($urandom_range(0, K-1)); din = DW'($urandom);
      end
      n++;
    end
    wr_en = 1'b0;
    check(done === 1'b1, "R6", "done after sort", done, 1);
    repeat (3) @(negedge clk);
    check(done === 1'b1, "R6", "done held with start high", done, 1);
    start = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R6", "done released after start low", done, 0);
    mode = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(done === 1'b0, "R1", "done after reset", done, 0);

    // load and read back
    for (int n = 0; n < K; n++) img[n] = DW'($urandom);
    load_img();
    verify("R2", "readback after load");

    // R3: dout holds while no read
    rd(AW'(3), v);
    check(v === img[3], "R3", "read entry 3", v, img[3]);
    @(negedge clk); addr = AW'(9);
    @(negedge clk);
    check(dout === img[3], "R3", "dout held without read", dout, img[3]);

    // R4: start ignored in init mode
    @(negedge clk); mode = 1'b0; start = 1'b1;
    repeat (20) @(negedge clk);
    check(done === 1'b0, "R4", "done with mode 0", done, 0);
    start = 1'b0;
    verify("R4", "table unchanged by start in mode 0");

    // R7: write in idle with mode 1
    wr(AW'(0), ~img[0], 1'b1);
    wr(AW'(K-1), ~img[K-1], 1'b1);
    verify("R7", "table unchanged by mode 1 write");

    // random sort with writes poked during the run
    run_sort(1'b1);
    sort_img();
    verify("R5", "sorted random table");
    rd(AW'(0), v);
    check(v === img[0], "R9", "minimum at address 0", v, img[0]);
    rd(AW'(K-1), v);
    check(v === img[K-1], "R9", "maximum at last address", v, img[K-1]);

    // R1: reset in the middle of a sort
    for (int n = 0; n < K; n++) img[n] = DW'(K - n);
    load_img();
    @(negedge clk); mode = 1'b1; start = 1'b1;
    repeat (10) @(negedge clk);
    rst = 1'b1; start = 1'b0; mode = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(done === 1'b0, "R1", "done after mid-sort reset", done, 0);
    wr(AW'(5), 8'hA5, 1'b0);
    rd(AW'(5), v);
    check(v === 8'hA5, "R1", "access after mid-sort reset", v, 8'hA5);

    // R8: reverse sorted, every pair exchanged
    for (int n = 0; n < K; n++) img[n] = DW'(200 - 7 * n);
    load_img();
    run_sort(1'b0);
    sort_img();
    verify("R8", "reverse table after exchanges");

    // R10 directed corners
    for (int n = 0; n < K; n++) img[n] = 8'd42;
    load_img(); run_sort(1'b0); sort_img();
    verify("R10", "all equal");
    for (int n = 0; n < K; n++) img[n] = DW'(3 * n);
    load_img(); run_sort(1'b0); sort_img();
    verify("R10", "already sorted");
    for (int n = 0; n < K; n++) img[n] = (n % 2 == 0) ? 8'hFF : 8'h00;
    load_img(); run_sort(1'b0); sort_img();
    verify("R10", "extremes interleaved");

    // random rounds, some with narrow ranges for duplicates
    for (int r = 0; r < 6; r++) begin
      for (int n = 0; n < K; n++)
        img[n] = (r % 2 == 0) ? DW'($urandom) : DW'($urandom_range(0, 3));
      load_img();
      run_sort(r == 1);
      sort_img();
      verify("R5", "random round");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule